// File: doc/BRIEF.md
# Dual-Accumulator Saturating Multiply-Accumulate Engine

This block is the arithmetic core of a 16-bit signal processor. In a single cycle it multiplies two 16-bit operands and writes the result into one of two 40-bit accumulators. The result can be the bare product, the accumulator plus the product, or the accumulator minus the product. Each operand is widened to 17 bits, and a per-operand control picks sign or zero extension, so signed, unsigned and mixed products all fit the same multiplier. Each accumulator carries 8 guard bits above a 32-bit result.

The same write path also serves a bidirectional barrel shifter. It moves the selected accumulator by up to 16 places in either direction within one cycle. Every accumulator write can optionally saturate at the 40-bit signed limits. Each accumulator has two sticky overflow flags: one for leaving the 32-bit range and one for leaving the 40-bit range. Instruction decode, operand fetch and address generation live elsewhere and drive the control inputs directly.

Top module: `dual_acc_mac`

## Requirements
- R1: After reset, both accumulators read zero and all four overflow flags are 0.
- R2: Operation codes are 0 no-op, 1 clear, 2 load product, 3 multiply-add, 4 multiply-subtract, 5 shift, and 6 and 7 act as no-ops. An operation presented at one rising edge shows its result in the accumulator chosen by `acc_sel` (0 = A, 1 = B) right after that edge. The other accumulator keeps its value.
- R3: Each operand is widened to 17 bits. When its signed control is 1 it is sign-extended; otherwise it is zero-extended. A load writes the full product, sign-extended to 40 bits.
- R4: Multiply-add writes accumulator + product, and multiply-subtract writes accumulator − product.
- R5: Clear writes zero to the selected accumulator.
- R6: A shift with a positive amount shifts the selected accumulator right arithmetically. A negative amount shifts it left and fills with zeros.
- R7: The 6-bit two's-complement shift amount is clamped to a magnitude of 16: +20 and +31 act as +16, and −20 acts as −16.
- R8: When a result exceeds the 40-bit signed range and `sat_en` is 1, the accumulator receives 0x7F_FFFF_FFFF for a positive result or 0x80_0000_0000 for a negative one. When `sat_en` is 0, it receives the low 40 bits of the result.
- R9: `ov32[i]` is set when a write to accumulator i produces a result outside the signed 32-bit range. `ov40[i]` is set when the result is outside the signed 40-bit range. Bit 0 belongs to A and bit 1 to B.
- R10: The flags are sticky. `ovf_clr` clears both flags of the accumulator selected by `acc_sel`. If an overflow on that same accumulator happens in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code |
| acc_sel | input | 1 | Target accumulator, 0 = A, 1 = B |
| opd_x | input | 16 | First multiplier operand |
| opd_y | input | 16 | Second multiplier operand |
| x_signed | input | 1 | Sign-extend first operand |
| y_signed | input | 1 | Sign-extend second operand |
| shift_amt | input | 6 | Signed shift amount, positive = right |
| sat_en | input | 1 | Saturate on 40-bit overflow |
| ovf_clr | input | 1 | Clear flags of the selected accumulator |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ov32 | output | 2 | Sticky 32-bit overflow flags |
| ov40 | output | 2 | Sticky 40-bit overflow flags |

## Verification
Flag clearing and overflow detection can both act on the same accumulator in the same cycle. The bench provokes this by asserting `ovf_clr` on the same edge as a left shift that overflows 40 bits. The flags must read set afterwards, and the wrapped value must read correctly. A second pairing is saturation during a shift: the bench drives left shifts of large positive and negative values with `sat_en` high and low. It judges the clamped or wrapped accumulator together with the flags it raised.

// File: rtl/dual_acc_mac.sv
module dual_acc_mac #(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  parameter int SHMAX = 16,
  parameter int SW    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                op,
  input  logic                      acc_sel,
  input  logic [DW-1:0]             opd_x,
  input  logic [DW-1:0]             opd_y,
  input  logic                      x_signed,
  input  logic                      y_signed,
  input  logic [SW-1:0]             shift_amt,
  input  logic                      sat_en,
  input  logic                      ovf_clr,
  output logic [2*DW+GUARD-1:0]     acc_a,
  output logic [2*DW+GUARD-1:0]     acc_b,
  output logic [1:0]                ov32,
  output logic [1:0]                ov40
);
  localparam int AW = 2*DW + GUARD;
  localparam int RW = 2*DW;
  localparam int EW = DW + 1;
  localparam int PW = 2*EW;
  localparam int XW = AW + SHMAX + 1;
  localparam logic [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  localparam logic [2:0] OP_CLR = 3'd1, OP_LOAD = 3'd2, OP_MAC = 3'd3,
                         OP_MSUB = 3'd4, OP_SHIFT = 3'd5;

  logic [AW-1:0] acc_q [2];
  logic [1:0] ov32_q, ov40_q;

  logic signed [EW-1:0] xw, yw;
  logic signed [PW-1:0] prod;
  assign xw   = {x_signed & opd_x[DW-1], opd_x};
  assign yw   = {y_signed & opd_y[DW-1], opd_y};
  assign prod = xw * yw;

  logic [AW-1:0] cur;
  logic signed [XW-1:0] cur_x, prod_x;
  assign cur    = acc_sel ? acc_q[1] : acc_q[0];
  assign cur_x  = {{(XW-AW){cur[AW-1]}}, cur};
  assign prod_x = {{(XW-PW){prod[PW-1]}}, prod};

  logic [SW-1:0] sh_neg, sh_mag, sh_lim;
  assign sh_neg = -shift_amt;
  assign sh_mag = shift_amt[SW-1] ? sh_neg : shift_amt;
  assign sh_lim = (sh_mag > SW'(SHMAX)) ? SW'(SHMAX) : sh_mag;

  logic signed [XW-1:0] raw;
  logic wr;
  always_comb begin
    wr  = 1'b1;
    raw = cur_x;
    case (op)
      OP_CLR:   raw = '0;
      OP_LOAD:  raw = prod_x;
      OP_MAC:   raw = cur_x + prod_x;
      OP_MSUB:  raw = cur_x - prod_x;
      OP_SHIFT: raw = shift_amt[SW-1] ? (cur_x <<< sh_lim) : (cur_x >>> sh_lim);
      default:  wr  = 1'b0;
    endcase
  end

  logic o40, o32;
  logic [AW-1:0] res;
  assign o40 = raw != {{(XW-AW){raw[AW-1]}}, raw[AW-1:0]};
  assign o32 = raw != {{(XW-RW){raw[RW-1]}}, raw[RW-1:0]};
  assign res = (sat_en && o40) ? (raw[XW-1] ? MINV : MAXV) : raw[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q[0] <= '0;
      acc_q[1] <= '0;
      ov32_q   <= '0;
      ov40_q   <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (wr && acc_sel == 1'(i)) acc_q[i] <= res;
        ov32_q[i] <= (ov32_q[i] & ~(ovf_clr && acc_sel == 1'(i)))
                   | (wr && acc_sel == 1'(i) && o32);
        ov40_q[i] <= (ov40_q[i] & ~(ovf_clr && acc_sel == 1'(i)))
                   | (wr && acc_sel == 1'(i) && o40);
      end
    end
  end

  assign acc_a = acc_q[0];
  assign acc_b = acc_q[1];
  assign ov32  = ov32_q;
  assign ov40  = ov40_q;

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR && !acc_sel) |=> acc_a == '0);
  a_r2_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_sel |=> $stable(acc_b));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ov40[1] && !(ovf_clr && acc_sel)) |=> ov40[1]);
  a_r9_ov40_implies_ov32: assert property (@(posedge clk) disable iff (!rst_n)
    ov40[0] |-> ov32[0]);
  a_r8_sat_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ov40[0]) && $past(sat_en) && !$past(acc_sel)) |-> (acc_a == MAXV || acc_a == MINV));
endmodule

// File: tb/dual_acc_mac_tb.sv
module dual_acc_mac_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] op = 0;
  logic acc_sel = 0, x_signed = 0, y_signed = 0, sat_en = 0, ovf_clr = 0;
  logic [15:0] opd_x = 0, opd_y = 0;
  logic [5:0] shift_amt = 0;
  logic [39:0] acc_a, acc_b;
  logic [1:0] ov32, ov40;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dual_acc_mac u_dut (.clk, .rst_n, .op, .acc_sel, .opd_x, .opd_y, .x_signed,
    .y_signed, .shift_amt, .sat_en, .ovf_clr, .acc_a, .acc_b, .ov32, .ov40);

  typedef struct packed {
    logic [2:0] op; logic [15:0] x; logic [15:0] y; logic xs; logic ys;
    logic [5:0] sh; logic [39:0] exp;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{3'd2, 16'd3,    16'd5, 1'b1, 1'b1, 6'd0,  40'd15},
    '{3'd3, 16'hFFFE, 16'd4, 1'b1, 1'b1, 6'd0,  40'd7},
    '{3'd4, 16'hFFFF, 16'd2, 1'b0, 1'b0, 6'd0,  40'hFFFFFE0009},
    '{3'd5, 16'd0,    16'd0, 1'b0, 1'b0, 6'h3C, 40'hFFFFE00090},
    '{3'd5, 16'd0,    16'd0, 1'b0, 1'b0, 6'd3,  40'hFFFFFC0012},
    '{3'd1, 16'd0,    16'd0, 1'b0, 1'b0, 6'd0,  40'd0}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic sel, input logic [15:0] x,
                      input logic [15:0] y, input logic xs, input logic ys,
                      input logic [5:0] sh, input logic sat, input logic clr);
    op = o; acc_sel = sel; opd_x = x; opd_y = y; x_signed = xs; y_signed = ys;
    shift_amt = sh; sat_en = sat; ovf_clr = clr;
    @(posedge clk); @(negedge clk);
    op = 0; ovf_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 acc_a", acc_a, 0); chk("R1 acc_b", acc_b, 0);
    chk("R1 flags", {ov32, ov40}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      step(VT[i].op, 1'b0, VT[i].x, VT[i].y, VT[i].xs, VT[i].ys, VT[i].sh, 1'b0, 1'b0);
      chk("R2 R3 R4 R5 R6 table acc_a", acc_a, VT[i].exp);
      chk("R2 table acc_b untouched", acc_b, 0);
      chk("R9 table no flags", {ov32, ov40}, 0);
    end

    // R3 mixed signedness
    step(3'd2, 0, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 0);
    chk("R3 mixed product", acc_a, 40'hFFFFFF0001);
    // R2 no-op codes
    step(3'd0, 0, 16'd7, 16'd7, 0, 0, 0, 0, 0);
    chk("R2 op0 no-op", acc_a, 40'hFFFFFF0001);
    step(3'd6, 0, 16'd7, 16'd7, 0, 0, 0, 0, 0);
    chk("R2 op6 no-op", acc_a, 40'hFFFFFF0001);
    step(3'd7, 0, 16'd7, 16'd7, 0, 0, 0, 0, 0);
    chk("R2 op7 no-op", acc_a, 40'hFFFFFF0001);

    // R9 32-bit overflow on B
    step(3'd2, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0);
    chk("R3 unsigned product B", acc_b, 40'h00FFFE0001);
    chk("R9 ov32_b set", ov32, 2'b10); chk("R9 ov40_b clear", ov40, 2'b00);
    chk("R2 acc_a untouched", acc_a, 40'hFFFFFF0001);
    step(3'd0, 1, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 clear flags B", {ov32, ov40}, 0);
    // R8 positive saturation
    step(3'd5, 1, 0, 0, 0, 0, 6'h30, 1, 0);
    chk("R8 sat positive", acc_b, 40'h7FFFFFFFFF);
    chk("R9 ov40_b set", {ov32, ov40}, 4'b1010);
    step(3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 sticky", {ov32, ov40}, 4'b1010);
    step(3'd0, 1, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 cleared", {ov32, ov40}, 0);
    // R8 wrap without saturation
    step(3'd2, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0);
    step(3'd5, 1, 0, 0, 0, 0, 6'h30, 0, 0);
    chk("R8 wrap", acc_b, 40'hFE00010000);
    // R10 clear and set in same cycle
    step(3'd5, 1, 0, 0, 0, 0, 6'h30, 0, 1);
    chk("R10 set wins value", acc_b, 40'h0100000000);
    chk("R10 set wins flags", {ov32, ov40}, 4'b1010);

    // R8 negative saturation on A
    step(3'd2, 0, 16'h8000, 16'h7FFF, 1, 1, 0, 0, 0);
    chk("R3 signed product", acc_a, 40'hFFC0008000);
    step(3'd5, 0, 0, 0, 0, 0, 6'h30, 1, 0);
    chk("R8 sat negative", acc_a, 40'h8000000000);
    chk("R9 ov40_a set", ov40, 2'b11);
    step(3'd0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 clear only A", {ov32, ov40}, 4'b1010);

    // R7 clamp
    step(3'd2, 0, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0);
    step(3'd5, 0, 0, 0, 0, 0, 6'd20, 0, 0);
    chk("R7 clamp +20", acc_a, 40'h000000FFFE);
    step(3'd5, 0, 0, 0, 0, 0, 6'b101100, 0, 0);
    chk("R7 clamp -20", acc_a, 40'h00FFFE0000);
    step(3'd5, 0, 0, 0, 0, 0, 6'd31, 0, 0);
    chk("R7 clamp +31", acc_a, 40'h000000FFFE);

    // R1 reset again
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    chk("R1 reset acc", {24'd0, acc_a}, 0);
    chk("R1 reset flags", {ov32, ov40}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule